// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers sixteen interrupt sources and steers each one to one of eight CPU interrupt lines. Four of the sources come from external pins, each synchronised and conditioned by its own sense setting. The sense setting selects the polarity and whether the pin is level-sensitive or edge-triggered. The other twelve sources are internal level signals that are already synchronous to the block clock.

Software programs the block over a simple 32-bit register bus. The programmable settings are:
- a destination and an enable for each source;
- an enable for each CPU line;
- the sense of each external pin.

Software reads back a 16-bit status word per CPU line. The status word shows which enabled, pending sources are routed to that line. Edge-captured sources stay pending until software writes a one to their bit in the clear register. A CPU line goes high when at least one status bit of its word is set and its line enable is on.

Register reads are combinational from the address. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `irq_router`

## Requirements
- R1: Under reset every register reads zero, no source is pending and all `cpu_irq` lines are low.
- R2: Source n owns a 4-bit field at bits 4*(n mod 8): bits [2:0] give the destination line and bit 3 is the source enable. Sources 0–7 sit in the word at address 0x00 and sources 8–15 in the word at 0x04. Both words read back as written.
- R3: The status word of line k is read at byte address 0x08 + 2*k, so lines 2j and 2j+1 share the word at 0x08 + 4*j in its low and high halves. Bit n is set exactly when source n is pending, enabled and routed to k, so a source appears in at most one status word.
- R4: A source whose enable bit is clear shows in no status word and drives no line. Writing zero to both routing words silences every source.
- R5: Line k has an enable at bit 16+k of the word at 0x18. While that bit is clear, `cpu_irq[k]` stays low, and the status word is unaffected.
- R6: `cpu_irq[k]` is registered. It rises one clock after its line enable and a non-empty status word are both present.
- R7: Writing to address 0x1C clears the pending state of every edge-captured source whose bit is 1, possibly several at once. Bits written as 0 leave their sources untouched.
- R8: Level sources follow their corrected input, delayed one clock for internal sources. A clear write has no lasting effect on a level source while its input stays asserted. External pins 0–3 drive sources 0–3, and internal inputs 0–11 drive sources 4–15.
- R9: Pin p has a 2-bit sense field at bits [2p+1:2p] of the word at 0x20. Bit 2p set means active-low, and bit 2p+1 set means level-sensitive. In edge mode a pin passes a two-flop synchroniser, and the source latches on the active edge and holds until cleared.
- R10: When a new active edge and a clear of the same source arrive at the same clock edge, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_irq_pin | input | 4 | Asynchronous external interrupt pins (sources 0–3) |
| int_irq | input | 12 | Synchronous internal level sources (sources 4–15) |
| cpu_irq | output | 8 | Registered active-high CPU interrupt lines |

## Verification
The bench walks every source to every line and checks the whole status word and all eight lines each time. A mis-decoded destination or a swapped status half-word therefore shows up as a wrong bit or a wrong line rather than a silent miss.

It drives pin 0 through all four sense settings. An inverted polarity bit would latch on the wrong edge, and a level source wrongly treated as latched would survive its input falling.

It writes multi-bit and all-zero clear masks to catch a clear that touches bits written as 0. It also lands a clear on the exact edge where a new capture arrives, which exposes a clear-over-set priority that loses the interrupt.

// File: rtl/irq_router_pkg.sv
// Package: shared types and register addresses of the interrupt router.
// Assumes byte addresses on an 8-bit bus and 32-bit data words.
package irq_router_pkg;

    localparam int DEST_W   = 3;
    localparam int FIELD_W  = DEST_W + 1;
    localparam int SRC_PER_WORD = 32 / FIELD_W;
    localparam int OE_LSB   = 16;
    localparam int STAT_W   = 16;

    localparam logic [7:0] ADR_ROUTE_BASE = 8'h00;
    localparam logic [7:0] ADR_STAT_BASE  = 8'h08;
    localparam logic [7:0] ADR_OUT_EN     = 8'h18;
    localparam logic [7:0] ADR_CLEAR      = 8'h1C;
    localparam logic [7:0] ADR_SENSE      = 8'h20;

    // Per-source routing nibble: enable on top, destination below.
    typedef struct packed {
        logic              enable;
        logic [DEST_W-1:0] dest;
    } route_field_t;

    // Per-pin sense pair: level flag on top, active-low flag below.
    typedef struct packed {
        logic level;
        logic active_low;
    } sense_t;

endpackage

// File: rtl/irq_pin_cond.sv
// Module: conditions one external interrupt pin.
// Synchronises the asynchronous pin through two flops and corrects its
// polarity. It delivers the corrected level and a one-cycle pulse on the
// active edge. Assumes the sense setting changes rarely. Because the
// polarity is applied to both the current and the delayed sample, a
// polarity change alone creates no edge.
module irq_pin_cond
    import irq_router_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin,
    input  sense_t sense,
    output logic   level_out,
    output logic   edge_pulse
);

    logic sync1_q, sync2_q, prev_q;

    // Two-flop synchroniser plus one delayed sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Polarity-corrected level and its rising edge.
    always_comb begin
        level_out  = sync2_q ^ sense.active_low;
        edge_pulse = level_out & ~(prev_q ^ sense.active_low);
    end

    // R9: the edge pulse lasts one cycle while the sense is unchanged.
    a_r9_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> (!edge_pulse || (sense != $past(sense))));

endmodule

// File: rtl/irq_pending.sv
// Module: pending state of every source.
// An edge source sets on its pulse and holds until a clear. When both
// arrive at the same clock edge, the set wins. A level source copies
// its input each cycle and ignores the clear. Assumes clr is a
// single-cycle mask taken from a bus write.
module irq_pending #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] is_level,
    input  logic [NUM_SRC-1:0] level_in,
    input  logic [NUM_SRC-1:0] edge_set,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        // Pending latch of source n with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[n] <= 1'b0;
            else if (is_level[n]) pend[n] <= level_in[n];
            else if (edge_set[n]) pend[n] <= 1'b1;
            else if (clr[n])      pend[n] <= 1'b0;
        end

        a_r9_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level[n] && pend[n] && !clr[n]) |=> pend[n]);
        a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level[n] && !edge_set[n] && clr[n]) |=> !pend[n]);
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level[n] && edge_set[n]) |=> pend[n]);
        a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            is_level[n] |=> (pend[n] == $past(level_in[n])));
    end

endmodule

// File: rtl/irq_regs.sv
// Module: register file and read multiplexer.
// Holds the routing fields, the line enables and the pin sense fields.
// Decodes the write-one-to-clear register into a single-cycle mask and
// returns read data combinationally from the address. Assumes at most
// 16 sources and at most 8 lines.
module irq_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_OUT = 8,
    parameter int NUM_EXT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_wr,
    input  logic [7:0]                       bus_addr,
    input  logic [31:0]                      bus_wdata,
    output logic [31:0]                      bus_rdata,
    input  logic [NUM_OUT-1:0][NUM_SRC-1:0]  status,
    output route_field_t [NUM_SRC-1:0]       route,
    output logic [NUM_OUT-1:0]               out_en,
    output sense_t [NUM_EXT-1:0]             sense,
    output logic [NUM_SRC-1:0]               clr_mask
);

    logic wr_stb;

    // Write strobe and the single-cycle clear mask.
    always_comb begin
        wr_stb   = bus_sel & bus_wr;
        clr_mask = (wr_stb && bus_addr == ADR_CLEAR) ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    // Programmable registers, updated on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route  <= '0;
            out_en <= '0;
            sense  <= '0;
        end else if (wr_stb) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr == 8'(ADR_ROUTE_BASE + 4 * (i / SRC_PER_WORD)))
                    route[i] <= bus_wdata[FIELD_W*(i%SRC_PER_WORD) +: FIELD_W];
            end
            if (bus_addr == ADR_OUT_EN)
                out_en <= bus_wdata[OE_LSB +: NUM_OUT];
            if (bus_addr == ADR_SENSE)
                sense <= bus_wdata[2*NUM_EXT-1:0];
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr == 8'(ADR_ROUTE_BASE + 4 * (i / SRC_PER_WORD)))
                bus_rdata[FIELD_W*(i%SRC_PER_WORD) +: FIELD_W] = route[i];
        end
        for (int k = 0; k < NUM_OUT; k++) begin
            if (bus_addr == 8'(ADR_STAT_BASE + 4 * (k / 2)))
                bus_rdata[STAT_W*(k%2) +: NUM_SRC] = status[k];
        end
        if (bus_addr == ADR_OUT_EN)
            bus_rdata[OE_LSB +: NUM_OUT] = out_en;
        if (bus_addr == ADR_SENSE)
            bus_rdata[2*NUM_EXT-1:0] = sense;
    end

    // R2: routing fields change only on a bus write.
    a_r2_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(route));

endmodule

// File: rtl/irq_route_out.sv
// Module: routes pending sources into status words and drives the lines.
// A status bit needs the source pending, enabled and routed to that
// line. Each line register goes high when its word is non-empty and its
// line enable is set. Assumes NUM_OUT fits the 3-bit destination.
module irq_route_out
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_OUT = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              pend,
    input  route_field_t [NUM_SRC-1:0]      route,
    input  logic [NUM_OUT-1:0]              out_en,
    output logic [NUM_OUT-1:0][NUM_SRC-1:0] status,
    output logic [NUM_OUT-1:0]              cpu_irq
);

    // Status matrix: one row per line, one column per source.
    always_comb begin
        for (int k = 0; k < NUM_OUT; k++)
            for (int n = 0; n < NUM_SRC; n++)
                status[k][n] = pend[n] & route[n].enable & (route[n].dest == DEST_W'(k));
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
        // Registered line output gated by its line enable.
        always_ff @(posedge clk) begin
            if (!rst_n) cpu_irq[k] <= 1'b0;
            else        cpu_irq[k] <= out_en[k] & (|status[k]);
        end

        a_r5_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[k] |-> $past(out_en[k]));
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
        logic [NUM_OUT-1:0] dest_col;

        // Gather source n's bit across all status rows.
        always_comb begin
            for (int k = 0; k < NUM_OUT; k++) dest_col[k] = status[k][n];
        end

        a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(dest_col));
        a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[n] |-> (dest_col == '0));
    end

endmodule

// File: rtl/irq_router.sv
// Module: top of the interrupt router.
// External pins 0..NUM_EXT-1 feed sources of the same number through
// pin conditioning. The internal level inputs feed the remaining
// sources. Assumes NUM_SRC <= 16 and NUM_OUT <= 8.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_OUT = 8,
    parameter int NUM_EXT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_EXT-1:0]         ext_irq_pin,
    input  logic [NUM_SRC-NUM_EXT-1:0] int_irq,
    output logic [NUM_OUT-1:0]         cpu_irq
);

    localparam int NUM_INT = NUM_SRC - NUM_EXT;

    route_field_t [NUM_SRC-1:0]       route;
    sense_t [NUM_EXT-1:0]             sense;
    logic [NUM_OUT-1:0]               out_en;
    logic [NUM_SRC-1:0]               clr_mask, pend;
    logic [NUM_SRC-1:0]               is_level, level_in, edge_set;
    logic [NUM_OUT-1:0][NUM_SRC-1:0]  status;

    irq_regs #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .NUM_EXT(NUM_EXT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .route(route), .out_en(out_en), .sense(sense),
        .clr_mask(clr_mask)
    );

    for (genvar p = 0; p < NUM_EXT; p++) begin : g_pin
        irq_pin_cond u_cond (
            .clk(clk), .rst_n(rst_n), .pin(ext_irq_pin[p]), .sense(sense[p]),
            .level_out(level_in[p]), .edge_pulse(edge_set[p])
        );
        assign is_level[p] = sense[p].level;
    end

    for (genvar i = 0; i < NUM_INT; i++) begin : g_int
        assign is_level[NUM_EXT+i] = 1'b1;
        assign level_in[NUM_EXT+i] = int_irq[i];
        assign edge_set[NUM_EXT+i] = 1'b0;
    end

    irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .is_level(is_level), .level_in(level_in),
        .edge_set(edge_set), .clr(clr_mask), .pend(pend)
    );

    irq_route_out #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .pend(pend), .route(route), .out_en(out_en),
        .status(status), .cpu_irq(cpu_irq)
    );

    // R1: lines are low in the cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> (cpu_irq == '0));

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ext_irq_pin = '0;
    logic [11:0] int_irq = '0;
    logic [7:0]  cpu_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_irq_pin(ext_irq_pin), .int_irq(int_irq), .cpu_irq(cpu_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(int n, logic v);
        if (n < 4) ext_irq_pin[n] = v;
        else       int_irq[n-4] = v;
    endtask

    function automatic logic [7:0] stat_addr(int k);
        return 8'(8'h08 + 4 * (k / 2));
    endfunction

    function automatic logic [31:0] stat_word(int k, logic [15:0] bits);
        return (k % 2 == 1) ? {bits, 16'h0} : {16'h0, bits};
    endfunction

    initial begin
        logic [31:0] d;

        // R1: reset state.
        idle(4);
        rst_n = 1'b1;
        foreach (d[i]) ;
        for (int a = 0; a <= 8'h20; a += 4) begin
            rd(8'(a), d);
            check($sformatf("R1 reset read %02h", a), d, 32'h0);
        end
        check("R1 reset lines", {24'h0, cpu_irq}, 32'h0);

        // R2: routing words read back as written.
        wr(8'h00, 32'h1234ABCD);
        wr(8'h04, 32'hF0E1D2C3);
        rd(8'h00, d); check("R2 readback low word", d, 32'h1234ABCD);
        rd(8'h04, d); check("R2 readback high word", d, 32'hF0E1D2C3);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);

        // R9 setup: all pins level, active-high; all lines enabled.
        wr(8'h20, 32'h000000AA);
        rd(8'h20, d); check("R9 sense readback", d, 32'h000000AA);
        wr(8'h18, 32'h00FF0000);
        rd(8'h18, d); check("R5 line enable readback", d, 32'h00FF0000);

        // R2/R3/R6/R8: every source to every line.
        for (int n = 0; n < 16; n++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] fld;
                fld = 32'(8 + k) << (4 * (n % 8));
                wr(8'h00, (n < 8) ? fld : 32'h0);
                wr(8'h04, (n < 8) ? 32'h0 : fld);
                set_src(n, 1'b1);
                idle(6);
                for (int j = 0; j < 8; j += 2) begin
                    logic [31:0] exp;
                    exp = 32'h0;
                    if (j == (k & 6)) exp = stat_word(k, 16'(1 << n));
                    rd(stat_addr(j), d);
                    check($sformatf("R3 status src %0d line %0d word %0d", n, k, j), d, exp);
                end
                check($sformatf("R6 line src %0d line %0d", n, k), {24'h0, cpu_irq}, 32'(1 << k));
                set_src(n, 1'b0);
                idle(6);
                check($sformatf("R8 release src %0d line %0d", n, k), {24'h0, cpu_irq}, 32'h0);
            end
        end

        // R4: source enable clear masks the source.
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
        wr(8'h00, 32'h00300000);                 // source 5 to line 3, disabled
        set_src(5, 1'b1); idle(4);
        rd(stat_addr(3), d); check("R4 disabled source status", d, 32'h0);
        check("R4 disabled source line", {24'h0, cpu_irq}, 32'h0);
        wr(8'h00, 32'h00B00000);                 // enable it
        idle(3);
        rd(stat_addr(3), d); check("R4 enabled source status", d, 32'h00200000);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);       // disable all
        idle(3);
        rd(stat_addr(3), d); check("R4 disable-all status", d, 32'h0);
        check("R4 disable-all line", {24'h0, cpu_irq}, 32'h0);

        // R5/R6: line enable gates the line, registered one cycle.
        wr(8'h00, 32'h00B00000);
        wr(8'h18, 32'h00040000);                 // only line 2 enabled
        idle(3);
        rd(stat_addr(3), d); check("R5 status kept with line off", d, 32'h00200000);
        check("R5 line 3 off", {24'h0, cpu_irq}, 32'h0);
        wr(8'h18, 32'h00080000);                 // enable line 3
        check("R6 line not yet high", {24'h0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R6 line high next cycle", {24'h0, cpu_irq}, 32'h00000008);
        set_src(5, 1'b0);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h00FF0000);

        // R9: pin 0 through all four sense settings, routed to line 0.
        wr(8'h00, 32'h00000008);
        // Edge, active-high.
        ext_irq_pin[0] = 1'b0;
        wr(8'h20, 32'h000000A8); idle(4); wr(8'h1C, 32'h1); idle(2);
        rd(8'h08, d); check("R9 edge-high idle", d, 32'h0);
        ext_irq_pin[0] = 1'b1; idle(2); ext_irq_pin[0] = 1'b0; idle(6);
        rd(8'h08, d); check("R9 edge-high captured and held", d, 32'h1);
        check("R9 edge-high line", {24'h0, cpu_irq}, 32'h1);
        wr(8'h1C, 32'h1); idle(2);
        rd(8'h08, d); check("R7 edge-high cleared", d, 32'h0);
        // Edge, active-low.
        ext_irq_pin[0] = 1'b1;
        wr(8'h20, 32'h000000A9); idle(4); wr(8'h1C, 32'h1); idle(2);
        rd(8'h08, d); check("R9 edge-low idle", d, 32'h0);
        ext_irq_pin[0] = 1'b0; idle(2); ext_irq_pin[0] = 1'b1; idle(6);
        rd(8'h08, d); check("R9 edge-low captured and held", d, 32'h1);
        wr(8'h1C, 32'h1); idle(2);
        rd(8'h08, d); check("R7 edge-low cleared", d, 32'h0);
        // Level, active-high.
        ext_irq_pin[0] = 1'b0;
        wr(8'h20, 32'h000000AA);
        ext_irq_pin[0] = 1'b1; idle(5);
        rd(8'h08, d); check("R9 level-high asserted", d, 32'h1);
        wr(8'h1C, 32'h1); idle(3);
        rd(8'h08, d); check("R8 level-high clear ignored", d, 32'h1);
        ext_irq_pin[0] = 1'b0; idle(5);
        rd(8'h08, d); check("R8 level-high released", d, 32'h0);
        // Level, active-low.
        wr(8'h20, 32'h000000AB); idle(5);
        rd(8'h08, d); check("R9 level-low idle high pin is active", d, 32'h1);
        ext_irq_pin[0] = 1'b1; idle(5);
        rd(8'h08, d); check("R9 level-low inactive", d, 32'h0);
        ext_irq_pin[0] = 1'b0; idle(5);
        rd(8'h08, d); check("R9 level-low active", d, 32'h1);
        ext_irq_pin[0] = 1'b1;

        // R7: multi-bit write-one-to-clear on four edge pins, line 1.
        wr(8'h20, 32'h0);
        wr(8'h00, 32'h00009999);
        ext_irq_pin = 4'h0; idle(4);
        wr(8'h1C, 32'hF); idle(2);
        rd(8'h08, d); check("R7 edge pins idle", d, 32'h0);
        ext_irq_pin = 4'hF; idle(2); ext_irq_pin = 4'h0; idle(6);
        rd(8'h08, d); check("R7 all four captured", d, 32'h000F0000);
        wr(8'h1C, 32'h5); idle(1);
        rd(8'h08, d); check("R7 clear mask 0101", d, 32'h000A0000);
        wr(8'h1C, 32'h0); idle(1);
        rd(8'h08, d); check("R7 zero mask no effect", d, 32'h000A0000);
        wr(8'h1C, 32'hA); idle(1);
        rd(8'h08, d); check("R7 clear mask 1010", d, 32'h0);

        // R10: a clear landing on the capture edge loses to the capture.
        @(negedge clk); ext_irq_pin[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        ext_irq_pin[0] = 1'b0; idle(3);
        rd(8'h08, d); check("R10 capture beats same-edge clear", d, 32'h00010000);
        wr(8'h1C, 32'h1); idle(1);
        rd(8'h08, d); check("R10 later clear takes effect", d, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule